// File: doc/BRIEF.md
# Complementary Output Stage with Break Protection

This block sits between the PWM compare logic and the gate drivers of a multi-leg power stage. For every leg it takes one reference PWM bit and produces a high-side drive and a complementary low-side drive. A programmable dead-time separates the switching of the two sides, so that one side is fully off before the other turns on.

Two fault inputs protect the power stage. The primary input is the OR of an external fault pin and an internal fault event. The secondary input is a second external pin, and the primary one takes precedence over it. Each fault input selects one of two responses: all drives off, or a programmed safe pattern per leg. Drive that the fault response does not want is removed combinationally, with no clock edge needed. Drive that the response does want, such as a low side turned on in the safe pattern, is still brought up through the dead-time path. Each fault is latched in a flag, and normal switching resumes only after software clears that flag while the input is inactive.

All pins are plain level controls with no handshake. The reference PWM is sampled on every clock, and the outputs are never stalled by anything downstream.

Top module: `pwm_guard`

## Requirements
- R1: With no fault active or latched, `hi_out[i]` settles to `duty_ref[i]` and `lo_out[i]` settles to its inverse within `dead_cycles`+3 clocks of a change in `duty_ref`.
- R2: When one side of a leg is switched off at a clock edge, the other side of that leg turns on exactly `dead_cycles`+1 edges later. A bench that samples on falling clock edges sees the turn-on at sample `dead_cycles`+2 after the reference changed. Turn-off takes effect at the first edge.
- R3: `hi_out[i]` and `lo_out[i]` are never both 1, under any mix of reference, dead-time and fault timing.
- R4: The primary fault is active when `prim_pin` equals `prim_pol`, or when `prim_int` is 1.
- R5: While the primary fault is active or latched, its response (`prim_safe`) applies whatever the secondary fault does. Only otherwise does the secondary response (`sec_safe`) apply.
- R6: The off response (select bit 0) drives all outputs to 0 in the same cycle the fault input becomes active, with no clock edge needed.
- R7: The safe response (select bit 1) targets `safe_hi`/`safe_lo` per leg, and a leg with both bits set is treated as both off. Any output the target does not want drops combinationally. Any output the target turns on follows the R2 dead-time.
- R8: `brk_flags[0]` (primary) and `brk_flags[1]` (secondary) are set at the first clock edge that sees the matching fault active. They stay set, and keep the fault response in force, after the input goes inactive.
- R9: A `flag_clr` high at a clock edge clears each flag whose fault input is inactive at that edge. It has no effect on a flag whose input is still active.
- R10: The secondary fault is active when `sec_pin` equals `sec_pol`, so either level can be chosen as the fault level for each pin.
- R11: While `rst_n` is low, all outputs and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_ref | input | LEGS | Reference PWM, one bit per leg |
| dead_cycles | input | DT_W | Dead-time in clock cycles |
| prim_pin | input | 1 | Primary external fault pin |
| prim_int | input | 1 | Internal fault event, ORed into the primary fault |
| prim_pol | input | 1 | Level of `prim_pin` that means fault |
| prim_safe | input | 1 | Primary response: 0 all off, 1 safe pattern |
| sec_pin | input | 1 | Secondary external fault pin |
| sec_pol | input | 1 | Level of `sec_pin` that means fault |
| sec_safe | input | 1 | Secondary response: 0 all off, 1 safe pattern |
| safe_hi | input | LEGS | Safe-pattern high-side levels |
| safe_lo | input | LEGS | Safe-pattern low-side levels |
| flag_clr | input | 1 | Clears latched fault flags whose input is inactive |
| hi_out | output | LEGS | High-side drives |
| lo_out | output | LEGS | Low-side drives |
| brk_flags | output | 2 | Latched faults: bit 0 primary, bit 1 secondary |

## Verification
The bench measures the exact sample at which the opposite side turns on after a reference change and after entry into a safe state with the high side conducting. A design that skipped or miscounted the dead-time would show the low side early, or would have both sides on at once. It checks the outputs immediately after a fault pin changes, with no clock edge in between, to catch a design that removes drive only at the next edge. It also stacks a secondary all-off fault under a primary safe fault, and pulses the clear while a fault input is still asserted. A wrong priority would leave the low side off, and an unconditional clear would drop the flag. A random phase mixes duty values, dead-times, fault pulses and clears, and counts every sample where a leg had both sides high.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;
  typedef enum logic [1:0] {
    DRV_RUN  = 2'd0,
    DRV_OFF  = 2'd1,
    DRV_SAFE = 2'd2
  } drive_sel_e;
endpackage

// File: rtl/pg_fault_ctl.sv
module pg_fault_ctl
  import pwm_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prim_pin,
  input  logic       prim_int,
  input  logic       prim_pol,
  input  logic       prim_safe,
  input  logic       sec_pin,
  input  logic       sec_pol,
  input  logic       sec_safe,
  input  logic       flag_clr,
  output logic [1:0] flags,
  output logic       fault_now,
  output drive_sel_e sel
);
  logic prim_act, sec_act;

  // raw fault levels, purely combinational so no clock is needed to act
  assign prim_act  = (prim_pin == prim_pol) | prim_int;
  assign sec_act   = (sec_pin == sec_pol);
  assign fault_now = prim_act | sec_act;

  // an active input re-sets its flag every edge, so a clear only wins once it is gone
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= 2'b00;
    end else begin
      flags[0] <= prim_act | (flags[0] & ~flag_clr);
      flags[1] <= sec_act  | (flags[1] & ~flag_clr);
    end
  end

  // primary first, secondary second, run otherwise
  always_comb begin
    if (prim_act | flags[0])     sel = prim_safe ? DRV_SAFE : DRV_OFF;
    else if (sec_act | flags[1]) sel = sec_safe  ? DRV_SAFE : DRV_OFF;
    else                         sel = DRV_RUN;
  end
endmodule

// File: rtl/pg_dead_leg.sv
module pg_dead_leg #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want_hi,
  input  logic            want_lo,
  input  logic [DT_W-1:0] dead,
  input  logic            cut,
  output logic            hi_drv,
  output logic            lo_drv
);
  localparam logic [DT_W-1:0] GAP_ONE = {{(DT_W-1){1'b0}}, 1'b1};
  localparam logic [DT_W-1:0] GAP_MAX = {DT_W{1'b1}};

  logic            hq, lq;
  logic [DT_W-1:0] gap;   // edges seen with both sides off, saturating
  logic            gap_ok;

  assign gap_ok = (gap >= dead);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hq  <= 1'b0;
      lq  <= 1'b0;
      gap <= '0;
    end else begin
      // turn-off is immediate; turn-on waits for the opposite side and the gap
      hq <= want_hi & (hq | (~lq & gap_ok));
      lq <= want_lo & (lq | (~hq & gap_ok));
      if (hq | lq)             gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + GAP_ONE;
    end
  end

  // while a fault is raw, anything the fault target does not want is removed at once
  assign hi_drv = hq & ~(cut & ~want_hi);
  assign lo_drv = lq & ~(cut & ~want_lo);
endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
  import pwm_guard_pkg::*;
#(
  parameter int LEGS = 3,
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LEGS-1:0] duty_ref,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic            prim_pin,
  input  logic            prim_int,
  input  logic            prim_pol,
  input  logic            prim_safe,
  input  logic            sec_pin,
  input  logic            sec_pol,
  input  logic            sec_safe,
  input  logic [LEGS-1:0] safe_hi,
  input  logic [LEGS-1:0] safe_lo,
  input  logic            flag_clr,
  output logic [LEGS-1:0] hi_out,
  output logic [LEGS-1:0] lo_out,
  output logic [1:0]      brk_flags
);
  drive_sel_e sel;
  logic       fault_now;

  pg_fault_ctl u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .prim_pin  (prim_pin),
    .prim_int  (prim_int),
    .prim_pol  (prim_pol),
    .prim_safe (prim_safe),
    .sec_pin   (sec_pin),
    .sec_pol   (sec_pol),
    .sec_safe  (sec_safe),
    .flag_clr  (flag_clr),
    .flags     (brk_flags),
    .fault_now (fault_now),
    .sel       (sel)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic th, tl;

    always_comb begin
      unique case (sel)
        DRV_RUN:  begin th = duty_ref[g];             tl = ~duty_ref[g];            end
        DRV_SAFE: begin th = safe_hi[g] & ~safe_lo[g]; tl = safe_lo[g] & ~safe_hi[g]; end
        default:  begin th = 1'b0;                     tl = 1'b0;                     end
      endcase
    end

    pg_dead_leg #(.DT_W(DT_W)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_hi (th),
      .want_lo (tl),
      .dead    (dead_cycles),
      .cut     (fault_now),
      .hi_drv  (hi_out[g]),
      .lo_drv  (lo_out[g])
    );
  end
endmodule

// File: rtl/pwm_guard_chk.sv
module pwm_guard_chk #(
  parameter int LEGS = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            prim_pin,
  input logic            prim_int,
  input logic            prim_pol,
  input logic            prim_safe,
  input logic            sec_pin,
  input logic            sec_pol,
  input logic            sec_safe,
  input logic [LEGS-1:0] safe_hi,
  input logic [LEGS-1:0] safe_lo,
  input logic            flag_clr,
  input logic [LEGS-1:0] hi_out,
  input logic [LEGS-1:0] lo_out,
  input logic [1:0]      brk_flags
);
  logic pa, sb;
  assign pa = (prim_pin == prim_pol) | prim_int;
  assign sb = (sec_pin == sec_pol);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_out & lo_out) == '0);

  p_lo_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_out & ~$past(lo_out)) != '0) |-> ((lo_out & ~$past(lo_out) & $past(hi_out)) == '0));

  p_hi_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_out & ~$past(hi_out)) != '0) |-> ((hi_out & ~$past(hi_out) & $past(lo_out)) == '0));

  p_prim_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pa && !prim_safe) |-> (hi_out == '0 && lo_out == '0));

  p_prim_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pa && prim_safe) |->
      ((hi_out & ~(safe_hi & ~safe_lo)) == '0 && (lo_out & ~(safe_lo & ~safe_hi)) == '0));

  p_sec_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pa && !brk_flags[0] && sb && !sec_safe) |-> (hi_out == '0 && lo_out == '0));

  p_prim_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pa |=> brk_flags[0]);

  p_sec_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sb |=> brk_flags[1]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flags[0] && !pa && flag_clr) |=> !brk_flags[0]);
endmodule

bind pwm_guard pwm_guard_chk #(.LEGS(LEGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prim_pin  (prim_pin),
  .prim_int  (prim_int),
  .prim_pol  (prim_pol),
  .prim_safe (prim_safe),
  .sec_pin   (sec_pin),
  .sec_pol   (sec_pol),
  .sec_safe  (sec_safe),
  .safe_hi   (safe_hi),
  .safe_lo   (safe_lo),
  .flag_clr  (flag_clr),
  .hi_out    (hi_out),
  .lo_out    (lo_out),
  .brk_flags (brk_flags)
);

// File: tb/pwm_guard_tb_top.sv
module pwm_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEGS = 3;
  localparam int DT_W = 8;

  // vector fields: {duty[2:0], dead[7:0], exp_hi[2:0], exp_lo[2:0]}
  localparam int NVEC = 6;
  localparam logic [16:0] VECS [NVEC] = '{
    {3'b101, 8'd0, 3'b101, 3'b010},
    {3'b010, 8'd0, 3'b010, 3'b101},
    {3'b111, 8'd2, 3'b111, 3'b000},
    {3'b000, 8'd5, 3'b000, 3'b111},
    {3'b110, 8'd9, 3'b110, 3'b001},
    {3'b011, 8'd1, 3'b011, 3'b100}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [LEGS-1:0] duty_ref = '0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic            prim_pin = 1'b0, prim_int = 1'b0, prim_pol = 1'b1, prim_safe = 1'b0;
  logic            sec_pin = 1'b0, sec_pol = 1'b1, sec_safe = 1'b0;
  logic [LEGS-1:0] safe_hi = '0, safe_lo = '0;
  logic            flag_clr = 1'b0;
  logic [LEGS-1:0] hi_out, lo_out;
  logic [1:0]      brk_flags;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_guard #(.LEGS(LEGS), .DT_W(DT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .duty_ref(duty_ref), .dead_cycles(dead_cycles),
    .prim_pin(prim_pin), .prim_int(prim_int), .prim_pol(prim_pol), .prim_safe(prim_safe),
    .sec_pin(sec_pin), .sec_pol(sec_pol), .sec_safe(sec_safe),
    .safe_hi(safe_hi), .safe_lo(safe_lo), .flag_clr(flag_clr),
    .hi_out(hi_out), .lo_out(lo_out), .brk_flags(brk_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  // counts samples until a leg-0 output turns on
  task automatic first_on(input bit want_lo, output int n);
    n = 0;
    for (int k = 1; k <= 40; k++) begin
      tick(1);
      if ((want_lo ? lo_out[0] : hi_out[0]) && n == 0) n = k;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int overlap;
    tick(3);
    // R11 reset state
    chk("R11 hi", 32'(hi_out), 0);
    chk("R11 lo", 32'(lo_out), 0);
    chk("R11 flags", 32'(brk_flags), 0);
    rst_n = 1'b1;
    tick(2);

    // R1 vector walk
    for (int v = 0; v < NVEC; v++) begin
      duty_ref    = VECS[v][16:14];
      dead_cycles = VECS[v][13:6];
      tick(int'(VECS[v][13:6]) + 4);
      chk("R1 hi", 32'(hi_out), 32'(VECS[v][5:3]));
      chk("R1 lo", 32'(lo_out), 32'(VECS[v][2:0]));
    end

    // R2 exact dead-time, both directions
    dead_cycles = 8'd3;
    duty_ref = 3'b000;
    tick(12);
    duty_ref = 3'b111;
    first_on(1'b0, n);
    chk("R2 hi turn-on sample", 32'(n), 5);
    duty_ref = 3'b000;
    first_on(1'b1, n);
    chk("R2 lo turn-on sample", 32'(n), 5);

    // R7/R6 safe entry with high side on
    duty_ref = 3'b111;
    tick(12);
    safe_hi = 3'b000; safe_lo = 3'b111; prim_safe = 1'b1;
    prim_pin = 1'b1;
    #1;
    chk("R7 hi dropped without edge", 32'(hi_out), 0);
    chk("R7 lo not yet on", 32'(lo_out), 0);
    first_on(1'b1, n);
    chk("R7 lo turn-on after dead-time", 32'(n), 5);
    chk("R8 primary flag", 32'(brk_flags), 1);
    prim_pin = 1'b0;
    tick(4);
    chk("R8 held after input gone hi", 32'(hi_out), 0);
    chk("R8 held after input gone lo", 32'(lo_out), 3'b111);
    clear_all();
    chk("R9 cleared", 32'(brk_flags), 0);
    tick(12);
    chk("R9 normal resumes", 32'(hi_out), 3'b111);

    // R9 clear ignored while active
    prim_pin = 1'b1;
    tick(1);
    clear_all();
    tick(1);
    chk("R9 clear ignored when active", 32'(brk_flags[0]), 1);
    prim_pin = 1'b0;
    tick(1);
    clear_all();
    tick(12);

    // R5 priority: secondary off, then primary safe
    sec_safe = 1'b0;
    sec_pin = 1'b1;
    #1;
    chk("R5 secondary off at once", 32'({hi_out, lo_out}), 0);
    tick(8);
    chk("R5 secondary held off", 32'({hi_out, lo_out}), 0);
    chk("R10 secondary flag", 32'(brk_flags), 2);
    prim_pin = 1'b1;
    tick(8);
    chk("R5 primary safe wins lo", 32'(lo_out), 3'b111);
    chk("R5 primary safe wins hi", 32'(hi_out), 0);
    prim_pin = 1'b0; sec_pin = 1'b0;
    tick(1);
    clear_all();
    tick(12);
    chk("R5 back to normal", 32'(hi_out), 3'b111);

    // R4 internal fault, off response
    prim_safe = 1'b0;
    prim_int = 1'b1;
    #1;
    chk("R4 internal fault off", 32'({hi_out, lo_out}), 0);
    tick(2);
    prim_int = 1'b0;
    tick(1);
    clear_all();
    tick(12);

    // R4/R10 polarity: fault level 0 on primary
    prim_pol = 1'b0;
    #1;
    chk("R4 low-level fault", 32'({hi_out, lo_out}), 0);
    prim_pin = 1'b1;
    tick(1);
    clear_all();
    tick(12);
    chk("R4 inactive high pin, normal", 32'(hi_out), 3'b111);
    prim_pol = 1'b1; prim_pin = 1'b0;
    tick(2);

    // R10 secondary polarity inverted
    sec_pol = 1'b0;
    #1;
    chk("R10 inverted secondary", 32'({hi_out, lo_out}), 0);
    sec_pin = 1'b1;
    tick(1);
    clear_all();
    tick(12);
    chk("R10 normal after", 32'(hi_out), 3'b111);
    sec_pol = 1'b1; sec_pin = 1'b0;
    tick(2);

    // R7 leg with both safe bits set goes fully off
    duty_ref = 3'b000;
    tick(12);
    safe_hi = 3'b001; safe_lo = 3'b111; prim_safe = 1'b1;
    prim_pin = 1'b1;
    tick(10);
    chk("R7 both-set leg hi", 32'(hi_out), 0);
    chk("R7 both-set leg lo", 32'(lo_out), 3'b110);
    prim_pin = 1'b0;
    tick(1);
    clear_all();
    tick(12);

    // R3 random duty, dead-time and fault timing
    overlap = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ((hi_out & lo_out) != 0) overlap++;
      if ($urandom_range(0, 3) == 0) duty_ref = 3'($urandom);
      if ($urandom_range(0, 199) == 0) dead_cycles = 8'($urandom_range(0, 6));
      if ($urandom_range(0, 59) == 0) prim_pin = ~prim_pin;
      if ($urandom_range(0, 59) == 0) sec_pin = ~sec_pin;
      if ($urandom_range(0, 99) == 0) prim_safe = ~prim_safe;
      if ($urandom_range(0, 99) == 0) begin safe_hi = 3'($urandom); safe_lo = 3'($urandom); end
      flag_clr = ($urandom_range(0, 9) == 0);
      #1;
      if ((hi_out & lo_out) != 0) overlap++;
    end
    chk("R3 no overlap under random stimulus", 32'(overlap), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule